// File: doc/BRIEF.md
# Legacy Virtual-Wire Interrupt Message Generator

This block sits on an upstream-facing port and turns four level-sensitive interrupt lines (wires A, B, C and D) into interrupt signalling messages. Each line is gated by its own disable bit. The block remembers which state it last announced for every wire. It produces an assert-message header when a wire's gated level becomes active and a deassert-message header when that level becomes inactive. Setting the disable bit of a wire that was announced as active counts as a fall, so a deassert message is sent for it.

Headers go out one at a time on a valid/ready interface. While several wires differ from their announced state, they are served lowest wire first. A wire is only compared again when the output slot can take a new header. If its level returns to the announced state before then, no message is produced for that wire.

Top module: `intx_msg_gen`

## Requirements
- R1: During reset `msg_valid` is 0. On leaving reset every wire counts as announced inactive, so a wire that is active at that point produces an assert message.
- R2: A gated level (`irq_in & ~irq_dis`) that becomes 1 on wire w (0 = A … 3 = D) makes `msg_valid` 1 after the next rising clock edge when the slot is free, with message code 0x20 + w.
- R3: A gated level that becomes 0 on a wire announced active produces a message with code 0x24 + w, with the same timing as R2.
- R4: A message is produced only when the gated level of a wire differs from its announced state. A steady level never produces a second message, and the assert and deassert messages of one wire always alternate.
- R5: Setting the disable bit of a wire announced active produces its deassert message. Clearing the bit while the input is still high produces its assert message again.
- R6: When several wires differ at once, they are served in order A, B, C, D. The next header is loaded in the same cycle that the previous one is accepted.
- R7: A wire whose level returns to its announced state before it is served produces no message.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and `msg_hdr` stays unchanged.
- R9: The 128-bit header holds four double words, with DW0 in bits 127:96. DW0 = 0x34000000: format 001 (4DW header, no payload), type 10100 (message, local routing), traffic class 0, attributes 00, length 0. DW1 = {requester ID, tag, code}, with the code in bits 71:64. DW2 and DW3 are zero.
- R10: A change on a wire whose disable bit is set, while that wire is announced inactive, produces no message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 4 | Level interrupt per wire, bit 0 = A |
| irq_dis | input | 4 | Per-wire disable, bit 0 = A |
| req_id | input | 16 | Requester ID placed in DW1 |
| msg_tag | input | 8 | Tag placed in DW1 |
| msg_valid | output | 1 | A header is available |
| msg_ready | input | 1 | Consumer accepts the header |
| msg_hdr | output | 128 | Message header, DW0 in the top bits |

## Verification
The bench raises three wires in the same cycle and checks the order and the back-to-back loading. A design with the priority reversed, or one that idles a cycle between headers, would deliver the codes in the wrong order or late. It sets the disable bit of an active wire and expects a deassert message. A design that only watches `irq_in` would stay silent there. It also toggles a disabled wire, where a wrong design would send spurious messages. While a header is stalled, the bench pulses another wire up and down. A design that latches edges instead of comparing levels would send an unwanted pair of messages. The bench also raises a wire during reset, so a design that samples the line at reset release misses the assert message.

// File: rtl/intx_pkg.sv
package intx_pkg;
    localparam int RID_W  = 16;
    localparam int TAG_W  = 8;
    localparam int CODE_W = 8;
    localparam int HDR_W  = 128;

    localparam logic [CODE_W-1:0] CODE_ASSERT_BASE   = 8'h20;
    localparam logic [CODE_W-1:0] CODE_DEASSERT_BASE = 8'h24;
    localparam logic [2:0]        FMT_4DW_NODATA     = 3'b001;
    localparam logic [4:0]        TYPE_MSG_LOCAL     = 5'b10100;

    typedef logic [HDR_W-1:0] hdr_t;

    function automatic logic [31:0] dw0_word();
        logic [31:0] w;
        w        = '0;
        w[31:29] = FMT_4DW_NODATA;
        w[28:24] = TYPE_MSG_LOCAL;
        w[22:20] = 3'b000;   // traffic class
        w[13:12] = 2'b00;    // attributes
        w[9:0]   = '0;       // length
        return w;
    endfunction
endpackage

// File: rtl/intx_pick.sv
module intx_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intx_hdr_fmt.sv
module intx_hdr_fmt
    import intx_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0]    wire_idx,
    input  logic             is_assert,
    input  logic [RID_W-1:0] rid,
    input  logic [TAG_W-1:0] tag,
    output hdr_t             hdr
);
    logic [CODE_W-1:0] code;

    always_comb begin
        code = (is_assert ? CODE_ASSERT_BASE : CODE_DEASSERT_BASE) + CODE_W'(wire_idx);
        hdr  = {dw0_word(), rid, tag, code, 64'h0};
    end
endmodule

// File: rtl/intx_msg_gen.sv
module intx_msg_gen
    import intx_pkg::*;
#(
    parameter int NUM_WIRES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WIRES-1:0] irq_in,
    input  logic [NUM_WIRES-1:0] irq_dis,
    input  logic [RID_W-1:0]     req_id,
    input  logic [TAG_W-1:0]     msg_tag,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [HDR_W-1:0]     msg_hdr
);
    localparam int IW = (NUM_WIRES > 1) ? $clog2(NUM_WIRES) : 1;

    typedef struct packed {
        logic [NUM_WIRES-1:0] sig;
        logic                 valid;
        hdr_t                 hdr;
    } state_t;

    state_t               st_d, st_q;
    logic [NUM_WIRES-1:0] level, pend;
    logic                 found;
    logic [IW-1:0]        sel;
    hdr_t                 new_hdr;

    assign level = irq_in & ~irq_dis;
    assign pend  = level ^ st_q.sig;

    intx_pick #(.N(NUM_WIRES)) i_pick (
        .req   (pend),
        .found (found),
        .idx   (sel)
    );

    intx_hdr_fmt #(.N(NUM_WIRES)) i_fmt (
        .wire_idx  (sel),
        .is_assert (level[sel]),
        .rid       (req_id),
        .tag       (msg_tag),
        .hdr       (new_hdr)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.valid && msg_ready) begin
            st_d.valid = 1'b0;
        end
        if ((!st_q.valid || msg_ready) && found) begin
            st_d.valid    = 1'b1;
            st_d.hdr      = new_hdr;
            st_d.sig[sel] = level[sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msg_valid = st_q.valid;
    assign msg_hdr   = st_q.hdr;
endmodule

// File: rtl/intx_msg_gen_chk.sv
module intx_msg_gen_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         msg_valid,
    input logic         msg_ready,
    input logic [127:0] msg_hdr
);
    logic [3:0] shadow_q;
    logic       hs;
    logic [7:0] code;

    assign hs   = msg_valid && msg_ready;
    assign code = msg_hdr[71:64];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (hs) begin
            shadow_q[code[1:0]] <= !code[2];
        end
    end

    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_hdr));

    a_r9_fixed_words: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_hdr[127:96] == 32'h3400_0000) && (msg_hdr[63:0] == 64'h0));

    a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (code[7:3] == 5'b00100));

    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        hs |-> (shadow_q[code[1:0]] == code[2]));
endmodule

bind intx_msg_gen intx_msg_gen_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_hdr   (msg_hdr)
);

// File: tb/test_intx_msg_gen.sv
module test_intx_msg_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   irq_in = '0;
    logic [3:0]   irq_dis = '0;
    logic [15:0]  req_id = 16'hBEEF;
    logic [7:0]   msg_tag = 8'h5A;
    logic         msg_valid;
    logic         msg_ready = 1'b0;
    logic [127:0] msg_hdr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    intx_msg_gen i_intx_msg_gen (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_dis(irq_dis),
        .req_id(req_id), .msg_tag(msg_tag), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_hdr(msg_hdr)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic take_msg(input logic [7:0] code, input string req);
        logic [127:0] exp;
        exp = {32'h3400_0000, req_id, msg_tag, code, 64'h0};
        check(msg_valid === 1'b1, {req, " valid"}, 128'(msg_valid), 128'd1);
        check(msg_hdr === exp, {req, " header"}, msg_hdr, exp);
        msg_ready = 1'b1;
        step();
        msg_ready = 1'b0;
    endtask

    task automatic expect_idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            check(msg_valid === 1'b0, req, 128'(msg_valid), 128'd0);
            step();
        end
    endtask

    task automatic t_reset();
        irq_in = 4'b0001;
        repeat (3) step();
        check(msg_valid === 1'b0, "R1 in reset", 128'(msg_valid), 128'd0);
        rst_n = 1'b1;
        step();
        take_msg(8'h20, "R1 active at release");
        irq_in = 4'b0000;
        step();
        take_msg(8'h24, "R3 A fall");
        expect_idle(2, "R1 idle");
    endtask

    task automatic t_single();
        irq_in[1] = 1'b1;
        step();
        take_msg(8'h21, "R2 B rise");
        expect_idle(3, "R4 steady high");
        irq_in[1] = 1'b0;
        step();
        take_msg(8'h25, "R3 B fall");
        expect_idle(2, "R4 steady low");
    endtask

    task automatic t_priority();
        req_id  = 16'h1234;
        msg_tag = 8'hC3;
        irq_in  = 4'b1101;
        step();
        take_msg(8'h20, "R6 first A");
        take_msg(8'h22, "R6 then C");
        take_msg(8'h23, "R6 then D");
        expect_idle(2, "R6 drained");
        irq_in = 4'b0000;
        step();
        take_msg(8'h24, "R6 fall A");
        take_msg(8'h26, "R6 fall C");
        take_msg(8'h27, "R6 fall D");
        expect_idle(2, "R6 drained again");
    endtask

    task automatic t_disable();
        irq_in[2] = 1'b1;
        step();
        take_msg(8'h22, "R2 C rise");
        irq_dis[2] = 1'b1;
        step();
        take_msg(8'h26, "R5 disable forces deassert");
        expect_idle(2, "R5 disabled quiet");
        irq_dis[2] = 1'b0;
        step();
        take_msg(8'h22, "R5 re-enable asserts");
        irq_in[2] = 1'b0;
        step();
        take_msg(8'h26, "R5 C fall");
        irq_dis[0] = 1'b1;
        irq_in[0]  = 1'b1;
        step();
        expect_idle(3, "R10 disabled rise");
        irq_in[0] = 1'b0;
        step();
        expect_idle(2, "R10 disabled fall");
        irq_dis[0] = 1'b0;
        step();
        expect_idle(2, "R10 enable while low");
    endtask

    task automatic t_toggle_back();
        logic [127:0] held;
        irq_in[0] = 1'b1;
        step();
        held = msg_hdr;
        irq_in[1] = 1'b1;
        step();
        check(msg_valid === 1'b1 && msg_hdr === held, "R8 hold under stall", msg_hdr, held);
        irq_in[1] = 1'b0;
        step();
        check(msg_valid === 1'b1 && msg_hdr === held, "R8 still held", msg_hdr, held);
        take_msg(8'h20, "R7 stalled A");
        expect_idle(3, "R7 B pulse dropped");
        irq_in[0] = 1'b0;
        step();
        take_msg(8'h24, "R3 A fall after stall");
    endtask

    initial begin
        t_reset();
        t_single();
        t_priority();
        t_disable();
        t_toggle_back();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule